// File: doc/BRIEF.md
# Dual-Slope Integrating ADC Sequencer

This block runs the digital side of an integrating converter with two timed phases. It drives an external integrator. After a start strobe it shorts the integration capacitor for a fixed number of cycles. It then routes the unknown input into the integrator for a fixed run-up count. Next it switches the integrator over to the negative reference. It counts clock ticks until the comparator reports that the integrator output is back at zero, and that tick count is the conversion result.

The comparator bit is asynchronous to the block's clock. It passes through a two-stage synchroniser before the sequencer acts on it. Conversions are slow, so only one is in flight at a time. A start strobe that arrives while a conversion is running has no effect. If the run-down goes on for 2^RES_W ticks without a comparator trip, the result is clamped to all-ones and an overrange flag is raised.

Top module: `dsadc_seq`

## Requirements
- R1: While rst_ni is low, and afterwards until the first start, busy_o=0, done_o=0, result_o=0, ovr_o=0, int_rst_o=1 and sel_ref_o=0.
- R2: A start_i pulse seen while busy_o=0 raises busy_o in the next cycle. int_rst_o then stays high for exactly RST_CYC cycles.
- R3: After the capacitor-reset phase, int_rst_o=0 and sel_ref_o=0 (input selected) hold for exactly RUNUP_TICKS cycles.
- R4: Right after run-up, sel_ref_o=1 (reference selected) and the tick count restarts at 0. sel_ref_o stays high for result_o+1 cycles, up to and including the cycle in which the result is captured.
- R5: result_o is the tick count during the first run-down cycle in which the synchronised comparator is high. The synchroniser delays cmp_i by two cycles. If the integrator needs k>0 discharge ticks to reach zero, the result is k+2. If cmp_i was already high before run-down began, the result is 0.
- R6: If the synchronised comparator is still low in the run-down cycle whose count is 2^RES_W-1, result_o becomes all-ones and ovr_o=1. Any conversion that trips in time clears ovr_o to 0.
- R7: done_o is high for exactly one cycle per conversion. busy_o is low in that cycle, and result_o and ovr_o are valid from that cycle onward.
- R8: A start_i pulse while busy_o=1 is ignored. The running conversion finishes with its normal timing and result, and no further conversion follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, used only when idle |
| cmp_i | input | 1 | Comparator, 1 = integrator at or below zero (asynchronous) |
| int_rst_o | output | 1 | 1 = short the integration capacitor |
| sel_ref_o | output | 1 | Input switch: 0 = unknown input, 1 = negative reference |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when the result is captured |
| result_o | output | RES_W | Run-down tick count |
| ovr_o | output | 1 | Run-down ran out of range, result saturated |

## Verification
The bench builds the block with RES_W=6, RUNUP_TICKS=16 and RST_CYC=3. With these values, the all-ones saturation point of 63 ticks lies within reach of a few hundred cycles per conversion. A behavioural integrator with a reference weight of 5 gives inputs whose results fall just below the clamp, exactly on it, and past it. It also gives a zero input, which trips before run-down begins, and inputs that end with a partial discharge tick. These cases test the two-tick synchroniser offset, the boundary between an all-ones result and overrange, and the clearing of ovr_o.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHORT = 2'd1,
    ST_RUNUP = 2'd2,
    ST_RUNDN = 2'd3
  } dsadc_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2  // must be >= 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dsadc_tick_cnt.sv
module dsadc_tick_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dsadc_fsm.sv
module dsadc_fsm
  import dsadc_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int RUNUP_TICKS = 1024,
  parameter int RST_CYC     = 4,
  parameter int CNT_W       = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_s_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             int_rst_o,
  output logic             sel_ref_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic             ovr_o
);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] RUNUP_LAST = CNT_W'(RUNUP_TICKS - 1);
  localparam logic [CNT_W-1:0] SAT_LAST   = CNT_W'((2 ** RES_W) - 1);

  dsadc_state_e state_q, state_d;
  logic fin_trip, fin_sat;

  always_comb begin
    state_d   = state_q;
    cnt_clr_o = 1'b0;
    fin_trip  = 1'b0;
    fin_sat   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_clr_o = 1'b1;
        if (start_i) state_d = ST_SHORT;
      end
      ST_SHORT: begin
        if (cnt_i == SHORT_LAST) begin
          cnt_clr_o = 1'b1;
          state_d   = ST_RUNUP;
        end
      end
      ST_RUNUP: begin
        if (cnt_i == RUNUP_LAST) begin
          cnt_clr_o = 1'b1;
          state_d   = ST_RUNDN;
        end
      end
      ST_RUNDN: begin
        if (cmp_s_i)                fin_trip = 1'b1;
        else if (cnt_i == SAT_LAST) fin_sat  = 1'b1;
        if (fin_trip || fin_sat) begin
          cnt_clr_o = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      done_o   <= 1'b0;
      result_o <= '0;
      ovr_o    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= fin_trip | fin_sat;
      if (fin_trip) begin
        result_o <= cnt_i[RES_W-1:0];
        ovr_o    <= 1'b0;
      end else if (fin_sat) begin
        result_o <= '1;
        ovr_o    <= 1'b1;
      end
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign int_rst_o = (state_q == ST_IDLE) || (state_q == ST_SHORT);
  assign sel_ref_o = (state_q == ST_RUNDN);

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && int_rst_o));

  p_rundn_from_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_ref_o) |-> (cnt_i == '0));

  p_sat_at_max_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ref_o && !cmp_s_i && cnt_i == SAT_LAST) |=> (done_o && ovr_o && (&result_o)));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_ignore_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !int_rst_o && start_i) |=> !(busy_o && int_rst_o));
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int RUNUP_TICKS = 1024,  // must be >= 2
  parameter int RST_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             int_rst_o,
  output logic             sel_ref_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic             ovr_o
);
  localparam int CNT_W = max3(RES_W, $clog2(RUNUP_TICKS), $clog2(RST_CYC));

  logic             cmp_s;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt;

  dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  dsadc_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .cnt_o (cnt)
  );

  dsadc_fsm #(
    .RES_W      (RES_W),
    .RUNUP_TICKS(RUNUP_TICKS),
    .RST_CYC    (RST_CYC),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .cmp_s_i  (cmp_s),
    .cnt_i    (cnt),
    .cnt_clr_o(cnt_clr),
    .int_rst_o(int_rst_o),
    .sel_ref_o(sel_ref_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o),
    .ovr_o    (ovr_o)
  );
endmodule

// File: tb/tb_dsadc_seq.sv
`timescale 1ns/1ps
module tb_dsadc_seq;
  localparam int RES_W = 6;
  localparam int RUNUP = 16;
  localparam int RSTC  = 3;
  localparam int VREF  = 5;
  localparam int N_VEC = 11;
  localparam int VEC_VIN [N_VEC] = '{0, 1, 2, 5, 7, 10, 13, 18, 19, 20, 30};
  localparam int VEC_RES [N_VEC] = '{0, 6, 9, 18, 25, 34, 44, 60, 63, 63, 63};
  localparam int VEC_OVR [N_VEC] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1};

  logic clk = 0, rst_n = 0, start = 0;
  logic cmp, int_rst, sel_ref, busy, done, ovr;
  logic [RES_W-1:0] result;
  int vin = 0, integ = 0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  // behavioural integrator and comparator
  always @(posedge clk) begin
    if (int_rst)      integ <= 0;
    else if (sel_ref) integ <= integ - VREF;
    else              integ <= integ + vin;
  end
  assign cmp = (integ <= 0);

  dsadc_seq #(.RES_W(RES_W), .RUNUP_TICKS(RUNUP), .RST_CYC(RSTC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp),
    .int_rst_o(int_rst), .sel_ref_o(sel_ref), .busy_o(busy),
    .done_o(done), .result_o(result), .ovr_o(ovr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input int v, input int exp_res, input int exp_ovr, input bit poke);
    int rc, up, dn, cyc;
    rc = 0; up = 0; dn = 0; cyc = 0;
    vin = v;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    while (!done) begin
      if (int_rst) rc++;
      else if (sel_ref) dn++;
      else up++;
      start = poke && (cyc == 1 || cyc == 10);
      @(negedge clk);
      cyc++;
    end
    start = 0;
    chk(rc == RSTC, "R2 short cycles", rc, RSTC);
    chk(up == RUNUP, "R3 run-up cycles", up, RUNUP);
    chk(dn == exp_res + 1, "R4 run-down cycles", dn, exp_res + 1);
    chk(int'(result) == exp_res, "R5 result", int'(result), exp_res);
    chk(int'(ovr) == exp_ovr, "R6 overrange", int'(ovr), exp_ovr);
    chk(busy == 1'b0, "R7 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", int'(done), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && int_rst == 1'b1, "R8 no retrigger", int'(busy), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && ovr == 0, "R1 flags in reset", int'({busy, done, ovr}), 0);
    chk(result == '0, "R1 result in reset", int'(result), 0);
    chk(int_rst == 1 && sel_ref == 0, "R1 switches in reset", int'({int_rst, sel_ref}), 2);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && int_rst == 1 && sel_ref == 0, "R1 idle after reset",
        int'({busy, int_rst, sel_ref}), 2);

    for (int i = 0; i < N_VEC; i++)
      run_conv(VEC_VIN[i], VEC_RES[i], VEC_OVR[i], 1'b0);

    // R6 flag clears on an in-range conversion after an overrange
    run_conv(1, 6, 0, 1'b0);
    // R8 start pulses during the capacitor short and the run-up are ignored
    run_conv(13, 44, 0, 1'b1);
    // R5 partial-tick case once more, back to back
    run_conv(3, 12, 0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule